// File: doc/BRIEF.md
# Core Module System Control Register Block

This block is the bank of system control registers that a processor core module exposes on a simple word-addressed register bus. It answers reads with a fixed identification word and a fixed status word. It keeps the oscillator settings behind a 16-bit unlock key, and it holds a control word whose bits drive an LED, a memory-remap level and a one-shot system reset request. It also provides two flag registers, each with its own set address and clear address, a free-running reference counter, and a read-only window onto a serial-presence-detect byte table that describes the fitted SDRAM.

The bus is single-cycle. A write is taken on the rising clock edge while `we_i` is high. Read data depends only on `addr_i` and the register state, so it is valid in the same cycle. The reference counter advances on a one-cycle enable that arrives from a divided reference clock, so the block uses only the system clock. The memory size is fixed at build time. It selects a size code in the SDRAM register and a density byte in the presence-detect table.

Top module: `cm_sysctrl`

## Requirements
- R1: Reading byte offset 0x000 returns 0x411A3001. Reading 0x010 returns 0x00100000. Writes to either offset change nothing.
- R2: A write to offset 0x014 keeps only the low 16 bits of the data as the key. A read of 0x014 returns the key with bit 16 set when the key is 0xA05F, and the plain key otherwise.
- R3: A write to the oscillator word (0x008) or the auxiliary oscillator word (0x01C) is accepted only while the stored key is 0xA05F. Otherwise the register keeps its old value.
- R4: The control word at 0x00C stores only data bits 0 and 2. Every other bit, including bit 3, reads back as 0.
- R5: A control write with data bit 3 set raises `sys_rst_req_o` for exactly the one cycle after the write edge.
- R6: `led_o` follows control bit 0. `remap_o` follows control bit 2, so boot flash is mapped at address zero while `remap_o` is 0. Both change only on a control write.
- R7: Offset 0x030 reads the flags register. A write there ORs the data into the register, and a write to 0x034 clears every bit that is 1 in the data.
- R8: The non-volatile flags behave the same way: they are read and OR-set at 0x038 and bit-cleared at 0x03C.
- R9: Offset 0x028 reads a 32-bit counter. The counter is 0 after reset, adds one on each cycle with `tick_i` high (modulo 2^32), and holds otherwise.
- R10: A read in 0x100..0x17F returns presence-detect byte ((offset-0x100)>>2) in bits 7:0. Byte 0 is 0x80, byte 1 is 0x08, byte 9 is 0xA0, and byte 31 is the density code (0x20 for 128 MB). Reads in 0x180..0x1FF return 0. Writes in 0x100..0x1FF change nothing.
- R11: After reset the registers hold these values: oscillator 0x01000048, auxiliary oscillator 0x0007FEFF, init 0x00000112, SDRAM 0x00011122 ORed with the size code (0x0C for 128 MB), key, control and flags all 0.
- R12: The SDRAM word (0x020) and the init word (0x024) can be read and written freely. Offsets that are not defined, the clear offsets included, read 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | ADDR_W (9) | Byte offset into the register space |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data for `addr_i`, valid in the same cycle |
| tick_i | input | 1 | Reference counter advance enable |
| sys_rst_req_o | output | 1 | One-cycle system reset request |
| remap_o | output | 1 | Memory remap level (1 = boot flash not at address zero) |
| led_o | output | 1 | LED drive |

## Verification
The key logic is tried with three patterns. First, oscillator writes with the reset key of 0. Then the same writes after the exact key is stored with garbage in its upper half. Last, a near-miss key. This separates a gate that compares all 16 key bits from one that tests too few bits or ignores the upper-half masking. The flag registers get overlapping set and clear masks, so OR-set, AND-clear and a mixed-up address pair each leave a different value behind. The presence-detect window is read at its first entry, at an entry in the middle, at its last entry and just past it, which exposes off-by-one and shift errors in the index. A write into the window checks that the table is read-only. A reset in mid-run checks that every register, the size-dependent SDRAM value included, returns to its reset value.

// File: rtl/cm_sysctrl_pkg.sv
package cm_sysctrl_pkg;

  localparam logic [31:0] ID_WORD     = 32'h411A_3001;
  localparam logic [31:0] STAT_WORD   = 32'h0010_0000;
  localparam logic [15:0] UNLOCK_KEY  = 16'hA05F;
  localparam logic [31:0] OSC_RST     = 32'h0100_0048;
  localparam logic [31:0] AUX_RST     = 32'h0007_FEFF;
  localparam logic [31:0] INIT_RST    = 32'h0000_0112;
  localparam logic [31:0] SDRAM_BASE  = 32'h0001_1122;

  // word indices in the low region (byte offset >> 2)
  localparam logic [5:0] W_ID        = 6'd0;
  localparam logic [5:0] W_OSC       = 6'd2;
  localparam logic [5:0] W_CTRL      = 6'd3;
  localparam logic [5:0] W_STAT      = 6'd4;
  localparam logic [5:0] W_LOCK      = 6'd5;
  localparam logic [5:0] W_AUX       = 6'd7;
  localparam logic [5:0] W_SDRAM     = 6'd8;
  localparam logic [5:0] W_INIT      = 6'd9;
  localparam logic [5:0] W_REFCNT    = 6'd10;
  localparam logic [5:0] W_FLAG_BASE = 6'd12;  // set at base, clear at base+1

  localparam int CTRL_LED   = 0;
  localparam int CTRL_REMAP = 2;
  localparam int CTRL_RESET = 3;

  function automatic logic [7:0] size_code(int mem_mb);
    if (mem_mb >= 256)      return 8'h10;
    else if (mem_mb >= 128) return 8'h0C;
    else if (mem_mb >= 64)  return 8'h08;
    else if (mem_mb >= 32)  return 8'h04;
    else                    return 8'h00;
  endfunction

  function automatic logic [7:0] spd_density(int mem_mb);
    if (mem_mb >= 256)      return 8'd64;
    else if (mem_mb >= 128) return 8'd32;
    else if (mem_mb >= 64)  return 8'd16;
    else if (mem_mb >= 32)  return 8'd4;
    else                    return 8'd2;
  endfunction

  function automatic logic [7:0] spd_byte(int idx, int mem_mb);
    case (idx)
      0:  return 8'd128;
      1:  return 8'd8;
      2:  return 8'd4;
      3:  return 8'd11;
      4:  return 8'd9;
      5:  return 8'd1;
      6:  return 8'd64;
      8:  return 8'd2;
      9:  return 8'hA0;
      10: return 8'hA0;
      13: return 8'd8;
      15: return 8'd1;
      16: return 8'h0E;
      17: return 8'd4;
      18: return 8'h1C;
      19: return 8'd1;
      20: return 8'd2;
      21: return 8'h20;
      22: return 8'hC0;
      27: return 8'h30;
      28: return 8'h28;
      29: return 8'h30;
      30: return 8'h28;
      31: return spd_density(mem_mb);
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cm_lock_gate.sv
module cm_lock_gate #(
  parameter int               KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY   = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [KEY_W-1:0] key_i,
  output logic [KEY_W-1:0] key_o,
  output logic             open_o
);
  logic [KEY_W-1:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   key_q <= '0;
    else if (wr_i) key_q <= key_i;
  end

  assign key_o  = key_q;
  assign open_o = (key_q == KEY);
endmodule

// File: rtl/cm_setclr_reg.sv
module cm_setclr_reg #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         set_i,
  input  logic         clr_i,
  input  logic [W-1:0] val_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= '0;
    else if (set_i)  q <= q | val_i;
    else if (clr_i)  q <= q & ~val_i;
  end

  assign q_o = q;
endmodule

// File: rtl/cm_refcnt.sv
module cm_refcnt #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cm_spd_window.sv
module cm_spd_window
  import cm_sysctrl_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int MEM_MB = 128
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o
);
  always_comb byte_o = spd_byte(int'(idx_i), MEM_MB);
endmodule

// File: rtl/cm_sysctrl.sv
module cm_sysctrl
  import cm_sysctrl_pkg::*;
#(
  parameter int MEM_MB = 128,
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              tick_i,
  output logic              sys_rst_req_o,
  output logic              remap_o,
  output logic              led_o
);
  localparam int WORD_W   = ADDR_W - 3;
  localparam int WIN_IDX  = ADDR_W - 4;
  localparam int KEY_W    = 16;
  localparam int NUM_FLAG = 2;
  localparam logic [DATA_W-1:0] SDRAM_RST = DATA_W'(SDRAM_BASE | {24'h0, size_code(MEM_MB)});

  logic              win_sel, win_hi, wr_lo;
  logic [WORD_W-1:0] word;
  logic [WIN_IDX-1:0] win_idx;
  logic              unused_addr;

  assign win_sel     = addr_i[ADDR_W-1];
  assign win_hi      = addr_i[ADDR_W-2];
  assign word        = addr_i[ADDR_W-2:2];
  assign win_idx     = addr_i[ADDR_W-3:2];
  assign wr_lo       = we_i & ~win_sel;
  assign unused_addr = ^addr_i[1:0];

  // key register and unlock detect
  logic [KEY_W-1:0] lock_key_w;
  logic             lock_open_w;

  cm_lock_gate #(.KEY_W(KEY_W), .KEY(UNLOCK_KEY)) u_lock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_lo && word == W_LOCK),
    .key_i  (wdata_i[KEY_W-1:0]),
    .key_o  (lock_key_w),
    .open_o (lock_open_w)
  );

  // plain and key-guarded registers
  logic [DATA_W-1:0] osc_q, aux_q, sdram_q, init_q;
  logic              led_q, remap_q, rst_req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_q     <= DATA_W'(OSC_RST);
      aux_q     <= DATA_W'(AUX_RST);
      sdram_q   <= SDRAM_RST;
      init_q    <= DATA_W'(INIT_RST);
      led_q     <= 1'b0;
      remap_q   <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      rst_req_q <= wr_lo && (word == W_CTRL) && wdata_i[CTRL_RESET];
      if (wr_lo) begin
        case (word)
          W_OSC:   if (lock_open_w) osc_q <= wdata_i;
          W_AUX:   if (lock_open_w) aux_q <= wdata_i;
          W_SDRAM: sdram_q <= wdata_i;
          W_INIT:  init_q  <= wdata_i;
          W_CTRL: begin
            led_q   <= wdata_i[CTRL_LED];
            remap_q <= wdata_i[CTRL_REMAP];
          end
          default: ;
        endcase
      end
    end
  end

  // set/clear flag pairs
  logic [DATA_W-1:0] flag_q [NUM_FLAG];

  for (genvar g = 0; g < NUM_FLAG; g++) begin : g_flag
    localparam logic [WORD_W-1:0] SET_WORD = WORD_W'(int'(W_FLAG_BASE) + 2*g);
    localparam logic [WORD_W-1:0] CLR_WORD = WORD_W'(int'(W_FLAG_BASE) + 2*g + 1);
    cm_setclr_reg #(.W(DATA_W)) u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (wr_lo && word == SET_WORD),
      .clr_i  (wr_lo && word == CLR_WORD),
      .val_i  (wdata_i),
      .q_o    (flag_q[g])
    );
  end

  // reference counter
  logic [CNT_W-1:0] refcnt_w;

  cm_refcnt #(.W(CNT_W)) u_refcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cnt_o  (refcnt_w)
  );

  // presence-detect window
  logic [7:0] spd_w;

  cm_spd_window #(.IDX_W(WIN_IDX), .MEM_MB(MEM_MB)) u_spd (
    .idx_i  (win_idx),
    .byte_o (spd_w)
  );

  // read mux
  always_comb begin
    rdata_o = '0;
    if (win_sel) begin
      if (!win_hi) rdata_o = DATA_W'(spd_w);
    end else begin
      case (word)
        W_ID:     rdata_o = DATA_W'(ID_WORD);
        W_STAT:   rdata_o = DATA_W'(STAT_WORD);
        W_OSC:    rdata_o = osc_q;
        W_AUX:    rdata_o = aux_q;
        W_SDRAM:  rdata_o = sdram_q;
        W_INIT:   rdata_o = init_q;
        W_CTRL:   rdata_o = DATA_W'({remap_q, 1'b0, led_q});
        W_LOCK:   rdata_o = DATA_W'({lock_open_w, lock_key_w});
        W_REFCNT: rdata_o = DATA_W'(refcnt_w);
        W_FLAG_BASE:                rdata_o = flag_q[0];
        WORD_W'(W_FLAG_BASE + 6'd2): rdata_o = flag_q[1];
        default:  rdata_o = '0;
      endcase
    end
  end

  assign sys_rst_req_o = rst_req_q;
  assign remap_o       = remap_q;
  assign led_o         = led_q;
endmodule

// File: rtl/cm_sysctrl_chk.sv
module cm_sysctrl_chk #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-3:0] word_i,
  input logic              rst_bit_i,
  input logic              tick_i,
  input logic              sys_rst_req_o,
  input logic              remap_o,
  input logic              led_o,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [DATA_W-1:0] osc_q,
  input logic [DATA_W-1:0] aux_q,
  input logic              lock_open
);
  logic ctrl_wr, osc_wr, aux_wr;
  assign ctrl_wr = we_i && word_i == (ADDR_W-2)'(3);
  assign osc_wr  = we_i && word_i == (ADDR_W-2)'(2);
  assign aux_wr  = we_i && word_i == (ADDR_W-2)'(7);

  AST_OSC_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_wr && !lock_open |=> $stable(osc_q)); // R3
  AST_AUX_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_wr && !lock_open |=> $stable(aux_q)); // R3
  AST_RST_REQ_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && rst_bit_i |=> sys_rst_req_o); // R5
  AST_RST_REQ_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ctrl_wr && rst_bit_i) |=> !sys_rst_req_o); // R5
  AST_LED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(led_o)); // R6
  AST_REMAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_wr |=> $stable(remap_o)); // R6
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == $past(cnt_q) + 1'b1); // R9
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cnt_q)); // R9
endmodule

bind cm_sysctrl cm_sysctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) chk_i (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .we_i          (we_i),
  .word_i        (addr_i[ADDR_W-1:2]),
  .rst_bit_i     (wdata_i[3]),
  .tick_i        (tick_i),
  .sys_rst_req_o (sys_rst_req_o),
  .remap_o       (remap_o),
  .led_o         (led_o),
  .cnt_q         (refcnt_w),
  .osc_q         (osc_q),
  .aux_q         (aux_q),
  .lock_open     (lock_open_w)
);

// File: tb/cm_sysctrl_tb_top.sv
module cm_sysctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [8:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        tick_i = 1'b0;
  logic        sys_rst_req_o, remap_o, led_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  cm_sysctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .tick_i(tick_i),
    .sys_rst_req_o(sys_rst_req_o), .remap_o(remap_o), .led_o(led_o)
  );

  typedef struct packed {
    logic        rd;
    logic [8:0]  addr;
    logic [31:0] data;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 43;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 9'h000, 32'h411A3001, 8'd1},  // R1 id
    '{1'b1, 9'h010, 32'h00100000, 8'd1},  // R1 status
    '{1'b0, 9'h000, 32'hFFFFFFFF, 8'd1},
    '{1'b1, 9'h000, 32'h411A3001, 8'd1},  // R1 write ignored
    '{1'b1, 9'h008, 32'h01000048, 8'd11}, // R11 reset values
    '{1'b1, 9'h01C, 32'h0007FEFF, 8'd11},
    '{1'b1, 9'h020, 32'h0001112E, 8'd11},
    '{1'b1, 9'h024, 32'h00000112, 8'd11},
    '{1'b1, 9'h014, 32'h00000000, 8'd2},  // R2 key resets to 0
    '{1'b0, 9'h008, 32'h12345678, 8'd3},
    '{1'b1, 9'h008, 32'h01000048, 8'd3},  // R3 locked write dropped
    '{1'b0, 9'h014, 32'hFFFFA05F, 8'd2},
    '{1'b1, 9'h014, 32'h0001A05F, 8'd2},  // R2 unlocked readback
    '{1'b0, 9'h008, 32'h12345678, 8'd3},
    '{1'b1, 9'h008, 32'h12345678, 8'd3},  // R3 unlocked write
    '{1'b0, 9'h01C, 32'h0000AAAA, 8'd3},
    '{1'b1, 9'h01C, 32'h0000AAAA, 8'd3},
    '{1'b0, 9'h014, 32'h0001A05E, 8'd2},
    '{1'b1, 9'h014, 32'h0000A05E, 8'd2},  // R2 near-miss key
    '{1'b0, 9'h01C, 32'h00000001, 8'd3},
    '{1'b1, 9'h01C, 32'h0000AAAA, 8'd3},  // R3 relocked
    '{1'b0, 9'h00C, 32'hFFFFFFF7, 8'd4},
    '{1'b1, 9'h00C, 32'h00000005, 8'd4},  // R4 only bits 0,2 kept
    '{1'b0, 9'h030, 32'h000000F0, 8'd7},
    '{1'b0, 9'h030, 32'h0000000F, 8'd7},
    '{1'b1, 9'h030, 32'h000000FF, 8'd7},  // R7 OR-set
    '{1'b0, 9'h034, 32'h0000003C, 8'd7},
    '{1'b1, 9'h030, 32'h000000C3, 8'd7},  // R7 clear
    '{1'b1, 9'h038, 32'h00000000, 8'd8},  // R8 untouched by flag writes
    '{1'b0, 9'h038, 32'h80000001, 8'd8},
    '{1'b0, 9'h03C, 32'h00000001, 8'd8},
    '{1'b1, 9'h038, 32'h80000000, 8'd8},  // R8 set then clear
    '{1'b1, 9'h034, 32'h00000000, 8'd12}, // R12 clear offset reads 0
    '{1'b0, 9'h020, 32'hDEADBEEF, 8'd12},
    '{1'b1, 9'h020, 32'hDEADBEEF, 8'd12}, // R12 sdram rw
    '{1'b0, 9'h044, 32'hFFFFFFFF, 8'd12},
    '{1'b1, 9'h044, 32'h00000000, 8'd12}, // R12 undefined
    '{1'b1, 9'h100, 32'h00000080, 8'd10}, // R10 first entry
    '{1'b1, 9'h124, 32'h000000A0, 8'd10}, // R10 entry 9
    '{1'b1, 9'h17C, 32'h00000020, 8'd10}, // R10 density byte
    '{1'b1, 9'h180, 32'h00000000, 8'd10}, // R10 past table
    '{1'b0, 9'h100, 32'h000000FF, 8'd10},
    '{1'b1, 9'h100, 32'h00000080, 8'd10}  // R10 read-only
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0; wdata_i = '0;
  endtask

  task automatic do_read(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
  endtask

  task automatic read_chk(input logic [8:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] d;
    do_read(a, d);
    check(d, exp, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] c0, c1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 outputs after reset
    check({29'b0, sys_rst_req_o, remap_o, led_o}, 32'h0, "R11 outputs at reset");
    read_chk(9'h00C, 32'h0, "R11 ctrl at reset");
    read_chk(9'h028, 32'h0, "R9 counter at reset");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].rd) read_chk(VEC[i].addr, VEC[i].data, $sformatf("R%0d vec %0d", VEC[i].req, i));
      else           do_write(VEC[i].addr, VEC[i].data);
    end

    // R6 levels follow ctrl bits 0 and 2 (set by vector write above)
    check({30'b0, remap_o, led_o}, 32'h3, "R6 led/remap set");
    do_write(9'h00C, 32'h00000001);
    check({30'b0, remap_o, led_o}, 32'h1, "R6 remap cleared, led on");
    do_write(9'h030, 32'h1);
    check({30'b0, remap_o, led_o}, 32'h1, "R6 held across other write");

    // R5 reset request pulse, R4 bit 3 reads 0
    do_write(9'h00C, 32'h00000008);
    #1 check({31'b0, sys_rst_req_o}, 32'h1, "R5 pulse high");
    @(negedge clk_i);
    #1 check({31'b0, sys_rst_req_o}, 32'h0, "R5 pulse one cycle");
    read_chk(9'h00C, 32'h0, "R4 reset bit reads 0");
    check({30'b0, remap_o, led_o}, 32'h0, "R6 cleared");

    // R9 counter
    do_read(9'h028, c0);
    @(negedge clk_i); tick_i = 1'b1;
    repeat (37) @(negedge clk_i);
    tick_i = 1'b0;
    do_read(9'h028, c1);
    check(c1, c0 + 32'd37, "R9 advance 37 ticks");
    repeat (5) @(negedge clk_i);
    read_chk(9'h028, c1, "R9 hold without tick");

    // R11 mid-run reset restores values
    do_write(9'h014, 32'h0000A05F);
    do_write(9'h008, 32'h0);
    do_write(9'h00C, 32'h5);
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
    read_chk(9'h008, 32'h01000048, "R11 osc after reset");
    read_chk(9'h014, 32'h0, "R11 key after reset");
    read_chk(9'h030, 32'h0, "R11 flags after reset");
    read_chk(9'h020, 32'h0001112E, "R11 sdram after reset");
    check({30'b0, remap_o, led_o}, 32'h0, "R11 ctrl outputs after reset");

    finish_run();
  end
endmodule